// File: doc/BRIEF.md
# Cluster Control Register File

This block is the shared control register file of a small multi-processor cluster. It has a global section and one register set per processor. The global section holds fixed identification values, the status of two attached sub-blocks (an interrupt controller and a power controller) and their base-address registers. Each sub-block base register drives a base-address output and an enable output. The top-level address decoder uses these outputs to place and switch on the sub-block.

Each processor has an "other" pointer and a reset-vector base. Software reaches them through two windows, and every bus access carries the ID of the requesting processor. The core-local window selects the requester's own set. The core-other window selects the set named by the requester's "other" pointer, so one processor can set up the boot vector of another processor before releasing it. Every reset base drives a sign-extended exception-base output for its processor.

Accesses are single-cycle. A write takes effect at the clock edge that samples it. Read data is registered: it appears on the cycle after the read and holds until the next read.

Top module: `cluster_ctrl_regs`

## Requirements
- R1: The global config word (offset 0x0000) reads 0. The base word (0x0004) reads parameter BLOCK_BASE. The revision word (0x0008) reads parameter REV_VALUE (default 0x800). The cache config word (0x0060) reads with only bit 20 (bypass) set.
- R2: The interrupt-controller status word (0x0048) reads 1 when `intc_present` is high and 0 otherwise. The power-controller status word (0x004C) reads the same way from `pwr_present`.
- R3: When its sub-block is present, a write to the interrupt-controller base (0x0040) or the power-controller base (0x0044) stores the written data ANDed with 0xFFFF8001. The register reads back that stored value. Its base output equals the stored value with bit 0 cleared, and its enable output equals bit 0.
- R4: A write to a sub-block base register while that sub-block's present strap is low has no effect on its readback or on its outputs.
- R5: The per-processor config word (window offset +0x10) reads N_PROC-1 in both the core-local window (0x2000) and the core-other window (0x4000).
- R6: In the core-local window (0x2000) an access selects the set of processor `bus_id`. In the core-other window (0x4000) it selects the set of the processor whose index is held in the "other" pointer of processor `bus_id`, taken before the access.
- R7: A write to the "other" pointer (window offset +0x18) is accepted only when write-data bits 7:0, read as an unsigned number, are below N_PROC. The pointer then takes that value. Otherwise the write is dropped. A read returns the pointer, zero-extended.
- R8: A write to the reset base (window offset +0x20) stores the data ANDed with 0xFFFFF000. From the next cycle, that processor's slice of `exc_base_flat` (bits i*VEC_W upward) equals the stored value sign-extended from bit 31 to VEC_W bits. The register reads back the stored value.
- R9: After reset, every "other" pointer is 0, every reset base is 0xBFC00000, both sub-block base registers are 0 with their enables low, and `bus_rdata` is 0.
- R10: An access to any word that R1 to R8 do not name returns 0 and changes no state. This covers unnamed offsets, window numbers 3 and above (address bits 15:13), and addresses that are not word-aligned.
- R11: `bus_rdata` updates only on the cycle after a read (`bus_en` high, `bus_we` low). During writes and idle cycles it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte offset into the block |
| bus_wdata | input | 32 | Write data |
| bus_id | input | ID_W | Index of the requesting processor |
| bus_rdata | output | 32 | Registered read data |
| intc_present | input | 1 | Interrupt-controller connected strap |
| pwr_present | input | 1 | Power-controller connected strap |
| exc_base_flat | output | N_PROC*VEC_W | Per-processor exception base, processor i in slice i |
| intc_base | output | 32 | Interrupt-controller base address |
| intc_en | output | 1 | Interrupt-controller enable |
| pwr_base | output | 32 | Power-controller base address |
| pwr_en | output | 1 | Power-controller enable |

## Verification
The hardest case to reach from the ports is a chain through the core-other window. In that case one processor writes to another processor's "other" pointer or reset base. The target is chosen by a pointer that an earlier write set, so the result depends on state from previous accesses. Directed steps set the pointers on purpose and then write through the window with a different requester ID. A long random phase mixes requester IDs, windows and pointer values, some of them out of range, and toggles the present straps. A bench model tracks every pointer, reset base and sub-block register, and predicts each readback and every exception-base output.

// File: rtl/ccr_pkg.sv
`timescale 1ns/1ps
package ccr_pkg;
   localparam int DATA_W        = 32;
   localparam int ADDR_W        = 16;
   localparam int OFS_W         = 13;
   localparam int OTHER_FIELD_W = 8;
   localparam int L2_BYPASS_BIT = 20;
   localparam int N_SUB         = 2;

   // window number is bus_addr[15:13]
   localparam logic [2:0] WIN_GLOBAL_NUM = 3'd0;
   localparam logic [2:0] WIN_LOCAL_NUM  = 3'd1;
   localparam logic [2:0] WIN_OTHER_NUM  = 3'd2;

   // global section offsets
   localparam logic [OFS_W-1:0] G_CONFIG    = 13'h000;
   localparam logic [OFS_W-1:0] G_BASE      = 13'h004;
   localparam logic [OFS_W-1:0] G_REV       = 13'h008;
   localparam logic [OFS_W-1:0] G_INTC_BASE = 13'h040;
   localparam logic [OFS_W-1:0] G_PWR_BASE  = 13'h044;
   localparam logic [OFS_W-1:0] G_INTC_STAT = 13'h048;
   localparam logic [OFS_W-1:0] G_PWR_STAT  = 13'h04C;
   localparam logic [OFS_W-1:0] G_L2CFG     = 13'h060;

   // per-processor window offsets
   localparam logic [OFS_W-1:0] P_CONFIG = 13'h010;
   localparam logic [OFS_W-1:0] P_OTHER  = 13'h018;
   localparam logic [OFS_W-1:0] P_RBASE  = 13'h020;

   localparam logic [DATA_W-1:0] RBASE_MASK    = 32'hFFFF_F000;
   localparam logic [DATA_W-1:0] RBASE_RESET   = 32'hBFC0_0000;
   localparam logic [DATA_W-1:0] SUB_ADDR_MASK = 32'hFFFF_8000;
   localparam logic [DATA_W-1:0] SUB_EN_MASK   = 32'h0000_0001;

   typedef enum logic [3:0] {
      K_NONE, K_CONFIG, K_BASE, K_REV, K_SUB_BASE, K_SUB_STAT,
      K_L2CFG, K_P_CONFIG, K_P_OTHER, K_P_RBASE
   } reg_kind_e;

   typedef enum logic [1:0] {W_GLOBAL, W_LOCAL, W_OTHER, W_NONE} win_e;

   typedef struct packed {
      win_e      win;
      reg_kind_e kind;
      logic      sub_idx;
   } dec_t;
endpackage

// File: rtl/ccr_decode.sv
`timescale 1ns/1ps
module ccr_decode
   import ccr_pkg::*;
(
   input  logic [ADDR_W-1:0] addr,
   output dec_t              dec
);
   logic [2:0]       win_sel;
   logic [OFS_W-1:0] ofs;

   assign win_sel = addr[ADDR_W-1:OFS_W];
   assign ofs     = addr[OFS_W-1:0];

   always_comb begin
      dec.win     = W_NONE;
      dec.kind    = K_NONE;
      dec.sub_idx = 1'b0;
      if (addr[1:0] == 2'b00) begin
         if (win_sel == WIN_GLOBAL_NUM) begin
            dec.win = W_GLOBAL;
            case (ofs)
               G_CONFIG:    dec.kind = K_CONFIG;
               G_BASE:      dec.kind = K_BASE;
               G_REV:       dec.kind = K_REV;
               G_INTC_BASE: begin dec.kind = K_SUB_BASE; dec.sub_idx = 1'b0; end
               G_PWR_BASE:  begin dec.kind = K_SUB_BASE; dec.sub_idx = 1'b1; end
               G_INTC_STAT: begin dec.kind = K_SUB_STAT; dec.sub_idx = 1'b0; end
               G_PWR_STAT:  begin dec.kind = K_SUB_STAT; dec.sub_idx = 1'b1; end
               G_L2CFG:     dec.kind = K_L2CFG;
               default:     dec.kind = K_NONE;
            endcase
         end else if (win_sel == WIN_LOCAL_NUM || win_sel == WIN_OTHER_NUM) begin
            dec.win = (win_sel == WIN_LOCAL_NUM) ? W_LOCAL : W_OTHER;
            case (ofs)
               P_CONFIG: dec.kind = K_P_CONFIG;
               P_OTHER:  dec.kind = K_P_OTHER;
               P_RBASE:  dec.kind = K_P_RBASE;
               default:  dec.kind = K_NONE;
            endcase
         end
      end
   end
endmodule

// File: rtl/ccr_proc_slot.sv
`timescale 1ns/1ps
module ccr_proc_slot
   import ccr_pkg::*;
#(
   parameter int N_PROC = 4,
   parameter int ID_W   = 2,
   parameter int VEC_W  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_other,
   input  logic              wr_rbase,
   input  logic [DATA_W-1:0] wdata,
   output logic [ID_W-1:0]   other_q,
   output logic [DATA_W-1:0] rbase_q,
   output logic [VEC_W-1:0]  exc_base
);
   logic in_range;

   // pointer field compared in full, so high-field bits cannot alias into range
   assign in_range = 32'(wdata[OTHER_FIELD_W-1:0]) < 32'(N_PROC);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         other_q <= '0;
         rbase_q <= RBASE_RESET & RBASE_MASK;
      end else begin
         if (wr_other && in_range) other_q <= wdata[ID_W-1:0];
         if (wr_rbase)             rbase_q <= wdata & RBASE_MASK;
      end
   end

   if (VEC_W > DATA_W) begin : g_sext
      assign exc_base = {{(VEC_W-DATA_W){rbase_q[DATA_W-1]}}, rbase_q};
   end else begin : g_narrow
      assign exc_base = rbase_q[VEC_W-1:0];
   end
endmodule

// File: rtl/ccr_sub_reg.sv
`timescale 1ns/1ps
module ccr_sub_reg
   import ccr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              present,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] val_q,
   output logic [DATA_W-1:0] base_addr,
   output logic              en
);
   always_ff @(posedge clk) begin
      if (!rst_n)              val_q <= '0;
      else if (wr && present)  val_q <= wdata & (SUB_ADDR_MASK | SUB_EN_MASK);
   end

   assign base_addr = val_q & SUB_ADDR_MASK;
   assign en        = val_q[0];
endmodule

// File: rtl/cluster_ctrl_regs.sv
`timescale 1ns/1ps
module cluster_ctrl_regs
   import ccr_pkg::*;
#(
   parameter int          N_PROC     = 4,
   parameter int          VEC_W      = 64,
   parameter logic [31:0] REV_VALUE  = 32'h0000_0800,
   parameter logic [31:0] BLOCK_BASE = 32'h1FBF_8000,
   localparam int         ID_W       = (N_PROC > 1) ? $clog2(N_PROC) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_en,
   input  logic                    bus_we,
   input  logic [15:0]             bus_addr,
   input  logic [31:0]             bus_wdata,
   input  logic [ID_W-1:0]         bus_id,
   output logic [31:0]             bus_rdata,
   input  logic                    intc_present,
   input  logic                    pwr_present,
   output logic [N_PROC*VEC_W-1:0] exc_base_flat,
   output logic [31:0]             intc_base,
   output logic                    intc_en,
   output logic [31:0]             pwr_base,
   output logic                    pwr_en
);
   if (N_PROC < 1 || N_PROC > (1 << OTHER_FIELD_W)) begin : g_bad_nproc
      $error("cluster_ctrl_regs: N_PROC must lie in 1..256");
   end
   if (VEC_W < DATA_W) begin : g_bad_vecw
      $error("cluster_ctrl_regs: VEC_W must be at least 32");
   end

   dec_t dec;
   ccr_decode u_dec (.addr(bus_addr), .dec(dec));

   logic                    wr_p;
   logic [ID_W-1:0]         other_q [N_PROC];
   logic [DATA_W-1:0]       rbase_q [N_PROC];
   logic [N_PROC*ID_W-1:0]  other_flat;
   logic [N_PROC-1:0]       wr_other;
   logic [N_PROC-1:0]       wr_rbase;
   logic [ID_W-1:0]         req_other;
   logic                    req_ok;
   logic [ID_W-1:0]         tgt_id;
   logic [ID_W-1:0]         tgt_other;
   logic [DATA_W-1:0]       tgt_rbase;
   logic [N_SUB-1:0]        present;
   logic [DATA_W-1:0]       sub_val  [N_SUB];
   logic [DATA_W-1:0]       sub_base [N_SUB];
   logic [N_SUB-1:0]        sub_en;
   logic [DATA_W-1:0]       rd_next;

   assign wr_p    = bus_en && bus_we;
   assign present = {pwr_present, intc_present};

   // resolve requester and window target
   always_comb begin
      req_other = '0;
      req_ok    = 1'b0;
      for (int i = 0; i < N_PROC; i++) begin
         if (bus_id == ID_W'(i)) begin
            req_other = other_q[i];
            req_ok    = 1'b1;
         end
      end
      tgt_id    = (dec.win == W_OTHER) ? req_other : bus_id;
      tgt_other = '0;
      tgt_rbase = '0;
      for (int i = 0; i < N_PROC; i++) begin
         if (tgt_id == ID_W'(i)) begin
            tgt_other = other_q[i];
            tgt_rbase = rbase_q[i];
         end
      end
   end

   for (genvar g = 0; g < N_PROC; g++) begin : g_slot
      assign wr_other[g] = wr_p && (dec.kind == K_P_OTHER) && req_ok && (tgt_id == ID_W'(g));
      assign wr_rbase[g] = wr_p && (dec.kind == K_P_RBASE) && req_ok && (tgt_id == ID_W'(g));

      ccr_proc_slot #(.N_PROC(N_PROC), .ID_W(ID_W), .VEC_W(VEC_W)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_other (wr_other[g]),
         .wr_rbase (wr_rbase[g]),
         .wdata    (bus_wdata),
         .other_q  (other_q[g]),
         .rbase_q  (rbase_q[g]),
         .exc_base (exc_base_flat[g*VEC_W +: VEC_W])
      );

      assign other_flat[g*ID_W +: ID_W] = other_q[g];
   end

   for (genvar s = 0; s < N_SUB; s++) begin : g_sub
      ccr_sub_reg u_sub (
         .clk       (clk),
         .rst_n     (rst_n),
         .present   (present[s]),
         .wr        (wr_p && (dec.kind == K_SUB_BASE) && (dec.sub_idx == 1'(s))),
         .wdata     (bus_wdata),
         .val_q     (sub_val[s]),
         .base_addr (sub_base[s]),
         .en        (sub_en[s])
      );
   end

   assign intc_base = sub_base[0];
   assign intc_en   = sub_en[0];
   assign pwr_base  = sub_base[1];
   assign pwr_en    = sub_en[1];

   always_comb begin
      case (dec.kind)
         K_CONFIG:   rd_next = '0;
         K_BASE:     rd_next = BLOCK_BASE;
         K_REV:      rd_next = REV_VALUE;
         K_SUB_BASE: rd_next = sub_val[dec.sub_idx];
         K_SUB_STAT: rd_next = {31'b0, present[dec.sub_idx]};
         K_L2CFG:    rd_next = 32'(1) << L2_BYPASS_BIT;
         K_P_CONFIG: rd_next = req_ok ? 32'(N_PROC - 1) : '0;
         K_P_OTHER:  rd_next = req_ok ? 32'(tgt_other) : '0;
         K_P_RBASE:  rd_next = req_ok ? tgt_rbase : '0;
         default:    rd_next = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                bus_rdata <= '0;
      else if (bus_en && !bus_we) bus_rdata <= rd_next;
   end
endmodule

// File: rtl/ccr_chk.sv
`timescale 1ns/1ps
module ccr_chk #(
   parameter int          N_PROC    = 4,
   parameter int          VEC_W     = 64,
   parameter logic [31:0] REV_VALUE = 32'h0000_0800,
   localparam int         ID_W      = (N_PROC > 1) ? $clog2(N_PROC) : 1
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    bus_en,
   input logic                    bus_we,
   input logic [15:0]             bus_addr,
   input logic [31:0]             bus_rdata,
   input logic                    intc_present,
   input logic                    pwr_present,
   input logic [31:0]             intc_base,
   input logic                    intc_en,
   input logic [31:0]             pwr_base,
   input logic                    pwr_en,
   input logic [N_PROC*VEC_W-1:0] exc_base_flat,
   input logic [N_PROC*ID_W-1:0]  other_flat
);
   a_r1_rev_value: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && !bus_we && bus_addr == 16'h0008) |=> (bus_rdata == REV_VALUE));

   a_r2_intc_status: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && !bus_we && bus_addr == 16'h0048) |=> (bus_rdata == {31'b0, $past(intc_present)}));

   a_r4_intc_absent: assert property (@(posedge clk) disable iff (!rst_n)
      !intc_present |=> ($stable(intc_base) && $stable(intc_en)));

   a_r4_pwr_absent: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_present |=> ($stable(pwr_base) && $stable(pwr_en)));

   a_r5_local_config: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && !bus_we && bus_addr == 16'h2010) |=> (bus_rdata == 32'(N_PROC - 1)));

   a_r7_other_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_en && bus_we) |=> $stable(other_flat));

   a_r8_exc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_en && bus_we) |=> $stable(exc_base_flat));

   a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_en && !bus_we) |=> $stable(bus_rdata));
endmodule

bind cluster_ctrl_regs ccr_chk #(.N_PROC(N_PROC), .VEC_W(VEC_W), .REV_VALUE(REV_VALUE)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .bus_en        (bus_en),
   .bus_we        (bus_we),
   .bus_addr      (bus_addr),
   .bus_rdata     (bus_rdata),
   .intc_present  (intc_present),
   .pwr_present   (pwr_present),
   .intc_base     (intc_base),
   .intc_en       (intc_en),
   .pwr_base      (pwr_base),
   .pwr_en        (pwr_en),
   .exc_base_flat (exc_base_flat),
   .other_flat    (other_flat)
);

// File: tb/cluster_ctrl_regs_tb.sv
`timescale 1ns/1ps
module cluster_ctrl_regs_tb;
   localparam int          NP    = 4;
   localparam int          VW    = 64;
   localparam logic [31:0] REV   = 32'h0000_0800;
   localparam logic [31:0] BBASE = 32'h1FBF_8000;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           bus_en = 1'b0, bus_we = 1'b0;
   logic [15:0]    bus_addr = '0;
   logic [31:0]    bus_wdata = '0;
   logic [1:0]     bus_id = '0;
   logic [31:0]    bus_rdata;
   logic           intc_present = 1'b1, pwr_present = 1'b0;
   logic [NP*VW-1:0] exc_base_flat;
   logic [31:0]    intc_base, pwr_base;
   logic           intc_en, pwr_en;

   int n_chk = 0;
   int n_fail = 0;

   logic [1:0]  m_other [NP];
   logic [31:0] m_rbase [NP];
   logic [31:0] m_sub   [2];

   always #4 clk = ~clk;   // 125 MHz

   cluster_ctrl_regs #(.N_PROC(NP), .VEC_W(VW), .REV_VALUE(REV), .BLOCK_BASE(BBASE)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_id(bus_id), .bus_rdata(bus_rdata),
      .intc_present(intc_present), .pwr_present(pwr_present),
      .exc_base_flat(exc_base_flat), .intc_base(intc_base), .intc_en(intc_en),
      .pwr_base(pwr_base), .pwr_en(pwr_en)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] sext(input logic [31:0] v);
      return {{32{v[31]}}, v};
   endfunction

   function automatic logic [31:0] exp_read(input logic [1:0] id, input logic [15:0] a);
      logic [2:0]  win;
      logic [12:0] ofs;
      logic [1:0]  t;
      win = a[15:13];
      ofs = a[12:0];
      if (a[1:0] != 2'b00) return 32'h0;
      if (win == 3'd0) begin
         case (ofs)
            13'h004: return BBASE;
            13'h008: return REV;
            13'h040: return m_sub[0];
            13'h044: return m_sub[1];
            13'h048: return {31'b0, intc_present};
            13'h04C: return {31'b0, pwr_present};
            13'h060: return 32'h0010_0000;
            default: return 32'h0;
         endcase
      end
      if (win == 3'd1 || win == 3'd2) begin
         t = (win == 3'd1) ? id : m_other[id];
         case (ofs)
            13'h010: return 32'(NP - 1);
            13'h018: return {30'b0, m_other[t]};
            13'h020: return m_rbase[t];
            default: return 32'h0;
         endcase
      end
      return 32'h0;
   endfunction

   task automatic model_write(input logic [1:0] id, input logic [15:0] a, input logic [31:0] d);
      logic [2:0]  win;
      logic [12:0] ofs;
      logic [1:0]  t;
      win = a[15:13];
      ofs = a[12:0];
      if (a[1:0] != 2'b00) return;
      if (win == 3'd0) begin
         if (ofs == 13'h040 && intc_present) m_sub[0] = d & 32'hFFFF_8001;
         if (ofs == 13'h044 && pwr_present)  m_sub[1] = d & 32'hFFFF_8001;
      end else if (win == 3'd1 || win == 3'd2) begin
         t = (win == 3'd1) ? id : m_other[id];
         if (ofs == 13'h018 && d[7:0] < 8'(NP)) m_other[t] = d[1:0];
         if (ofs == 13'h020) m_rbase[t] = d & 32'hFFFF_F000;
      end
   endtask

   task automatic bus_write(input logic [1:0] id, input logic [15:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b1; bus_id = id; bus_addr = a; bus_wdata = d;
      model_write(id, a, d);
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] id, input logic [15:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b0; bus_id = id; bus_addr = a;
      @(negedge clk);
      bus_en = 1'b0;
      d = bus_rdata;
   endtask

   task automatic read_chk(input string tag, input logic [1:0] id, input logic [15:0] a);
      logic [31:0] e;
      logic [31:0] d;
      e = exp_read(id, a);
      bus_read(id, a, d);
      chk(tag, 64'(d), 64'(e));
   endtask

   task automatic outs_chk(input string tag);
      for (int i = 0; i < NP; i++) chk({tag, " exc_base"}, exc_base_flat[i*VW +: VW], sext(m_rbase[i]));
      chk({tag, " intc_base"}, 64'(intc_base), 64'(m_sub[0] & 32'hFFFF_8000));
      chk({tag, " intc_en"},   64'(intc_en),   64'(m_sub[0][0]));
      chk({tag, " pwr_base"},  64'(pwr_base),  64'(m_sub[1] & 32'hFFFF_8000));
      chk({tag, " pwr_en"},    64'(pwr_en),    64'(m_sub[1][0]));
   endtask

   task automatic sweep_chk(input string tag);
      for (int id = 0; id < NP; id++) begin
         read_chk(tag, 2'(id), 16'h2018);
         read_chk(tag, 2'(id), 16'h2020);
      end
      read_chk(tag, 2'd0, 16'h0040);
      read_chk(tag, 2'd0, 16'h0044);
   endtask

   initial begin : watchdog
      #(8 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      logic [15:0] alist [20];
      logic [31:0] d, prev;
      logic [31:0] seed_dummy;
      alist = '{16'h0000, 16'h0004, 16'h0008, 16'h0040, 16'h0044, 16'h0048, 16'h004C,
                16'h0060, 16'h2010, 16'h2018, 16'h2020, 16'h4010, 16'h4018, 16'h4020,
                16'h2018, 16'h4018, 16'h2020, 16'h0100, 16'h6018, 16'h2022};
      for (int i = 0; i < NP; i++) begin
         m_other[i] = 2'd0;
         m_rbase[i] = 32'hBFC0_0000;
      end
      m_sub[0] = '0;
      m_sub[1] = '0;
      seed_dummy = $urandom(32'h5EED_0042);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R9 reset state
      chk("R9 rdata after reset", 64'(bus_rdata), 64'h0);
      outs_chk("R9 reset");
      chk("R9 exc_base0 value", exc_base_flat[0 +: VW], 64'hFFFF_FFFF_BFC0_0000);
      sweep_chk("R9 reset readback");

      // R1 constants
      read_chk("R1 config", 2'd0, 16'h0000);
      read_chk("R1 base",   2'd1, 16'h0004);
      read_chk("R1 rev",    2'd2, 16'h0008);
      read_chk("R1 l2cfg",  2'd3, 16'h0060);

      // R2 status
      read_chk("R2 intc status", 2'd0, 16'h0048);
      read_chk("R2 pwr status",  2'd0, 16'h004C);
      intc_present = 1'b0; pwr_present = 1'b1;
      read_chk("R2 intc status low", 2'd0, 16'h0048);
      read_chk("R2 pwr status high", 2'd0, 16'h004C);
      intc_present = 1'b1; pwr_present = 1'b0;

      // R3 present write
      bus_write(2'd0, 16'h0040, 32'h1234_5677);
      outs_chk("R3 intc write");
      chk("R3 intc_base value", 64'(intc_base), 64'h1234_0000);
      read_chk("R3 intc readback", 2'd0, 16'h0040);

      // R4 absent write
      bus_write(2'd0, 16'h0044, 32'hFFFF_FFFF);
      outs_chk("R4 pwr absent");
      read_chk("R4 pwr readback", 2'd0, 16'h0044);

      // R5 config in both windows
      read_chk("R5 local config", 2'd2, 16'h2010);
      read_chk("R5 other config", 2'd1, 16'h4010);

      // R7 bound check on the full byte
      bus_write(2'd1, 16'h2018, 32'h0000_0104);
      read_chk("R7 out-of-range dropped", 2'd1, 16'h2018);
      bus_write(2'd1, 16'h2018, 32'h0000_0103);
      read_chk("R7 in-range accepted", 2'd1, 16'h2018);

      // R6/R8 other window targets processor 3
      bus_write(2'd1, 16'h4020, 32'h8000_1ABC);
      outs_chk("R8 other-window rbase");
      chk("R8 exc_base3 sign-extended", exc_base_flat[3*VW +: VW], 64'hFFFF_FFFF_8000_1000);
      bus_write(2'd1, 16'h4018, 32'h0000_0002);
      read_chk("R6 other of proc3 via local", 2'd3, 16'h2018);
      read_chk("R6 other via other window", 2'd1, 16'h4018);
      bus_write(2'd2, 16'h2020, 32'h0123_4FFF);
      chk("R8 exc_base2 positive", exc_base_flat[2*VW +: VW], 64'h0000_0000_0123_4000);
      read_chk("R6 chained rbase", 2'd3, 16'h4020);

      // R10 unimplemented / misaligned writes
      bus_write(2'd0, 16'h0100, 32'hFFFF_FFFF);
      bus_write(2'd0, 16'h2024, 32'hFFFF_FFFF);
      bus_write(2'd0, 16'h6018, 32'h0000_0001);
      bus_write(2'd0, 16'h2022, 32'h0000_0003);
      bus_write(2'd0, 16'h0042, 32'h0000_FFFF);
      outs_chk("R10 no side effect");
      sweep_chk("R10 state intact");
      read_chk("R10 unimpl read", 2'd0, 16'h0100);
      read_chk("R10 window3 read", 2'd0, 16'h6020);

      // R11 hold during writes
      bus_read(2'd0, 16'h0008, prev);
      bus_write(2'd0, 16'h2020, 32'h1000_0000);
      chk("R11 rdata held over write", 64'(bus_rdata), 64'(prev));
      repeat (2) @(negedge clk);
      chk("R11 rdata held idle", 64'(bus_rdata), 64'(prev));

      // random mix
      for (int n = 0; n < 600; n++) begin
         logic [15:0] a;
         logic [1:0]  id;
         a  = alist[$urandom % 20];
         id = 2'($urandom % NP);
         if (n % 150 == 75) begin
            intc_present = $urandom % 2 == 0;
            pwr_present  = $urandom % 2 == 0;
         end
         if ($urandom % 2 == 0) begin
            d = $urandom;
            if ($urandom % 2 == 0) d = (d & 32'hFFFF_FF00) | ($urandom % 6);
            bus_write(id, a, d);
            outs_chk("R6 R8 random write");
         end else begin
            read_chk("R6 R7 random read", id, a);
         end
      end
      sweep_chk("R6 final sweep");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule